// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Model

This block is a synthesizable model of a quad-data-rate static memory. It has a write data input and a read data output that work independently of each other. Both ports move data at double data rate, and every access transfers a fixed burst of two words. One address bus is shared by time: in each memory cycle it first carries a read address and then a write address. A read and a write can therefore start in every cycle, with no bus turnaround between them.

The model runs from a single clock at twice the memory-cycle rate. An internal phase state machine (`PH_K` → `PH_KN` → `PH_K` …) labels each rising edge:
- A K edge opens a memory cycle.
- A K# edge falls halfway through it.

The `k_phase` output tells the driving logic which kind of edge comes next.

The write path is a three-state machine:
- `WR_IDLE` moves to `WR_BEAT0` on a selected K# edge.
- `WR_BEAT0` moves to `WR_BEAT1` on the next K edge, where the first word is captured.
- `WR_BEAT1` leaves on the next K# edge, where the second word is captured. It goes to `WR_BEAT0` if another write is selected at that edge, and to `WR_IDLE` otherwise.

A completed burst sits in a posted-write register for one half-cycle. It is committed to the array on the following K edge.

The read path is also a three-state machine:
- `RD_IDLE` moves to `RD_PEND` on a selected K edge.
- `RD_PEND` moves to `RD_FETCH` on the following K# edge.
- `RD_FETCH` leaves on the next K edge. There it takes both words of the burst, from the array or from the posted write when its address matches, and goes to `RD_PEND` if a new read is selected at that edge, or to `RD_IDLE` otherwise.

The `lat_mode` input selects the delay from read-address capture to the first output word: one memory cycle or one and a half. An echo output toggles on every edge, in step with the output data register.

Top module: `qdr2_burst_sram`

## Requirements
- R1: The read select `rd_sel_n` is active low and is sampled only on K edges. When it is high on a K edge, no read starts and `rvalid` stays low in the slots where that read's data would have appeared.
- R2: The write select `wr_sel_n` is active low and is sampled only on K# edges. When it is high, the address and data on the bus at that edge and the two edges that follow do not change the array.
- R3: A write whose address is captured on a K# edge takes word 0 from `wdata` on the next K edge and word 1 on the K# edge after that. A later read of that address returns word 0 first and then word 1.
- R4: With `lat_mode` = 0, word 0 of a read captured on K edge n is on `rdata` after edge n+2, and word 1 after edge n+3. Edges are counted on `clk2x`.
- R5: With `lat_mode` = 1, word 0 of a read captured on K edge n is on `rdata` after edge n+3, and word 1 after edge n+4.
- R6: `rvalid` is high for exactly the two output beats of each read and low otherwise. The word-1 beat always immediately follows the word-0 beat.
- R7: A read captured on the K edge just after a write's address edge returns that write's data, even though the write has not yet been committed to the array.
- R8: A read captured on the K edge before a write's address edge, in the same memory cycle, returns the data that was there before that write.
- R9: A read and a write can start in every memory cycle, back to back, in either latency mode. Every read returns data that matches R7 and R8.
- R10: `k_phase` is 1 after reset and alternates on every `clk2x` edge. `echo_clk` toggles on every `clk2x` edge.
- R11: While `rst_n` is low, `rvalid` is 0, `rdata` is 0 and `k_phase` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the memory-cycle rate; its rising edges alternate between K and K# |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_mode | input | 1 | Read latency select: 0 for one memory cycle, 1 for one and a half |
| rd_sel_n | input | 1 | Active-low read select, sampled on K edges |
| wr_sel_n | input | 1 | Active-low write select, sampled on K# edges |
| addr | input | ADDR_W | Shared address: the read address at K edges and the write address at K# edges |
| wdata | input | DATA_W | Write data: word 0 at the K edge and word 1 at the K# edge after the write address |
| rdata | output | DATA_W | Registered read data, one word per edge |
| rvalid | output | 1 | High while `rdata` holds a read beat |
| echo_clk | output | 1 | Toggles on every edge, in step with `rdata` |
| k_phase | output | 1 | 1 when the next `clk2x` edge is a K edge |

## Verification
On every cycle, the embedded assertions check the following:
- The phase and echo outputs alternate.
- The write machine only waits for word 0 ahead of a K edge.
- A posted write is always committed on a K edge.
- A read fetch falls on a K edge.
- A fetch is followed by the word-0 beat after one edge in short-latency mode and after two edges in long-latency mode.
- The word-1 beat immediately follows word 0.

The assertions cannot see whether the data is correct. The bench scenarios cover that:
- Sweeps over every address in both latency modes compare each returned word against an arithmetic model.
- These sweeps show forwarding of a write that has not yet been committed, the old-data result of a read issued just before a write, and write words landing in the right order.
- Separate scenarios show that a deselected read produces no beats and that a deselected write leaves memory untouched.

// File: rtl/qdr2_pkg.sv
package qdr2_pkg;

    // Which kind of K-clock edge the current clk2x edge represents.
    typedef enum logic {
        PH_K  = 1'b0,
        PH_KN = 1'b1
    } phase_e;

    // Write burst sequencer states.
    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_BEAT0 = 2'd1,
        WR_BEAT1 = 2'd2
    } wr_state_e;

    // Read address sequencer states.
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_PEND  = 2'd1,
        RD_FETCH = 2'd2
    } rd_state_e;

endpackage

// File: rtl/qdr2_wr_ctl.sv
module qdr2_wr_ctl
    import qdr2_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_edge,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              post_valid,
    output logic [ADDR_W-1:0] post_addr,
    output logic [DATA_W-1:0] post_w0,
    output logic [DATA_W-1:0] post_w1
);

    wr_state_e state, state_nx;
    logic [ADDR_W-1:0] waddr_q;
    logic [DATA_W-1:0] w0_q;
    logic addr_take;

    assign addr_take = !k_edge && !wr_sel_n;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            WR_IDLE:  if (addr_take) state_nx = WR_BEAT0;
            WR_BEAT0: if (k_edge) state_nx = WR_BEAT1;
            WR_BEAT1: if (!k_edge) state_nx = addr_take ? WR_BEAT0 : WR_IDLE;
            default:  state_nx = WR_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= state_nx;
    end

    // Datapath and posted-write register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waddr_q    <= '0;
            w0_q       <= '0;
            post_valid <= 1'b0;
            post_addr  <= '0;
            post_w0    <= '0;
            post_w1    <= '0;
        end else begin
            if (addr_take) waddr_q <= addr;
            if (state == WR_BEAT0 && k_edge) w0_q <= wdata;
            if (state == WR_BEAT1 && !k_edge) begin
                post_valid <= 1'b1;
                post_addr  <= waddr_q;
                post_w0    <= w0_q;
                post_w1    <= wdata;
            end else if (k_edge) begin
                post_valid <= 1'b0;
            end
        end
    end

    // Word 0 is always awaited ahead of a K edge
    assert_beat0_on_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_BEAT0) |-> k_edge);

    // A posted burst is always committed on a K edge
    assert_post_commit_on_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |-> k_edge);

endmodule

// File: rtl/qdr2_array.sv
module qdr2_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              commit,
    input  logic              post_valid,
    input  logic [ADDR_W-1:0] post_addr,
    input  logic [DATA_W-1:0] post_w0,
    input  logic [DATA_W-1:0] post_w1,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rd_w0,
    output logic [DATA_W-1:0] rd_w1
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LINE_W = 2 * DATA_W;

    logic [LINE_W-1:0] mem [DEPTH];
    logic hit;

    always_ff @(posedge clk) begin
        if (commit) mem[post_addr] <= {post_w1, post_w0};
    end

    // Coherency: a matching posted burst wins over the array line
    assign hit = post_valid && (post_addr == raddr);
    assign {rd_w1, rd_w0} = hit ? {post_w1, post_w0} : mem[raddr];

endmodule

// File: rtl/qdr2_rd_ctl.sv
module qdr2_rd_ctl
    import qdr2_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_edge,
    input  logic              lat_mode,
    input  logic              rd_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] arr_w0,
    input  logic [DATA_W-1:0] arr_w1,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    rd_state_e state, state_nx;
    logic addr_take, fetch_fire;
    logic b0_due, b1_due, first_q;
    logic [DATA_W-1:0] rbuf0, rbuf1;
    logic emit, emit_first;
    logic [DATA_W-1:0] emit_word;

    assign addr_take  = k_edge && !rd_sel_n;
    assign fetch_fire = (state == RD_FETCH) && k_edge;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE:  if (addr_take) state_nx = RD_PEND;
            RD_PEND:  if (!k_edge) state_nx = RD_FETCH;
            RD_FETCH: if (k_edge) state_nx = addr_take ? RD_PEND : RD_IDLE;
            default:  state_nx = RD_IDLE;
        endcase
    end

    // State register and address latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_IDLE;
            raddr <= '0;
        end else begin
            state <= state_nx;
            if (addr_take) raddr <= addr;
        end
    end

    // Beat selection: short latency sends word 0 straight from the fetch
    always_comb begin
        emit       = 1'b0;
        emit_first = 1'b0;
        emit_word  = '0;
        if (fetch_fire && !lat_mode) begin
            emit = 1'b1; emit_first = 1'b1; emit_word = arr_w0;
        end else if (b0_due) begin
            emit = 1'b1; emit_first = 1'b1; emit_word = rbuf0;
        end else if (b1_due) begin
            emit = 1'b1; emit_word = rbuf1;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbuf0   <= '0;
            rbuf1   <= '0;
            b0_due  <= 1'b0;
            b1_due  <= 1'b0;
            first_q <= 1'b0;
            rvalid  <= 1'b0;
            rdata   <= '0;
        end else begin
            if (fetch_fire) begin
                rbuf0 <= arr_w0;
                rbuf1 <= arr_w1;
            end
            b0_due  <= fetch_fire && lat_mode;
            b1_due  <= (fetch_fire && !lat_mode) || b0_due;
            first_q <= emit_first;
            rvalid  <= emit;
            if (emit) rdata <= emit_word;
        end
    end

    assert_fetch_on_k_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_FETCH) |-> k_edge);

    assert_short_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_fire && !lat_mode) |=> (rvalid && first_q));

    assert_long_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_fire && lat_mode) |=> ##1 (rvalid && first_q));

    assert_second_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && first_q) |=> (rvalid && !first_q));

endmodule

// File: rtl/qdr2_burst_sram.sv
module qdr2_burst_sram
    import qdr2_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              lat_mode,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              echo_clk,
    output logic              k_phase
);

    phase_e ph;
    logic k_edge;
    logic post_valid;
    logic [ADDR_W-1:0] post_addr, raddr;
    logic [DATA_W-1:0] post_w0, post_w1, arr_w0, arr_w1;

    // Phase state machine: K and K# edges alternate
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) ph <= PH_K;
        else        ph <= (ph == PH_K) ? PH_KN : PH_K;
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) echo_clk <= 1'b0;
        else        echo_clk <= ~echo_clk;
    end

    assign k_edge  = (ph == PH_K);
    assign k_phase = k_edge;

    qdr2_wr_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk        (clk2x),
        .rst_n      (rst_n),
        .k_edge     (k_edge),
        .wr_sel_n   (wr_sel_n),
        .addr       (addr),
        .wdata      (wdata),
        .post_valid (post_valid),
        .post_addr  (post_addr),
        .post_w0    (post_w0),
        .post_w1    (post_w1)
    );

    qdr2_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk        (clk2x),
        .commit     (post_valid && k_edge),
        .post_valid (post_valid),
        .post_addr  (post_addr),
        .post_w0    (post_w0),
        .post_w1    (post_w1),
        .raddr      (raddr),
        .rd_w0      (arr_w0),
        .rd_w1      (arr_w1)
    );

    qdr2_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk      (clk2x),
        .rst_n    (rst_n),
        .k_edge   (k_edge),
        .lat_mode (lat_mode),
        .rd_sel_n (rd_sel_n),
        .addr     (addr),
        .arr_w0   (arr_w0),
        .arr_w1   (arr_w1),
        .raddr    (raddr),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    assert_phase_alternates_R10: assert property (@(posedge clk2x) disable iff (!rst_n)
        k_phase |=> !k_phase);

    assert_phase_returns_R10: assert property (@(posedge clk2x) disable iff (!rst_n)
        !k_phase |=> k_phase);

    assert_echo_toggles_R10: assert property (@(posedge clk2x) disable iff (!rst_n)
        echo_clk |=> !echo_clk);

endmodule

// File: tb/test_qdr2_burst_sram.sv
module test_qdr2_burst_sram;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk2x = 1'b0;
    always #2 clk2x = ~clk2x;

    logic rst_n, lat_mode, rd_sel_n, wr_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic rvalid, echo_clk, k_phase;

    qdr2_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) i_qdr2_burst_sram (
        .clk2x(clk2x), .rst_n(rst_n), .lat_mode(lat_mode),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .echo_clk(echo_clk), .k_phase(k_phase)
    );

    int checks = 0;
    int fails = 0;
    int h = 0;
    bit done = 0;
    logic prev_echo;
    string vtag = "R6";

    logic [DW-1:0] model0 [DEPTH];
    logic [DW-1:0] model1 [DEPTH];
    logic          exp_v [8];
    logic [DW-1:0] exp_d [8];
    string         exp_tag [8];
    logic [DW-1:0] pend_w0, pend_w1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_half();
        int s = h % 8;
        chk(rvalid === exp_v[s], vtag, "rvalid", int'(rvalid), int'(exp_v[s]));
        if (exp_v[s])
            chk(rdata === exp_d[s], exp_tag[s], "rdata", int'(rdata), int'(exp_d[s]));
        chk(echo_clk !== prev_echo, "R10", "echo_clk", int'(echo_clk), int'(!prev_echo));
        prev_echo = echo_clk;
        exp_v[s] = 1'b0;
        h++;
    endtask

    // One memory cycle: K half (read slot, word 0) then K# half (write slot, word 1)
    task automatic kcycle(input bit rd, input int ra, input bit wr, input int wa,
                          input logic [DW-1:0] nw0, input logic [DW-1:0] nw1,
                          input string tag);
        int d0;
        chk(k_phase === 1'b1, "R10", "k_phase before K", int'(k_phase), 1);
        addr = AW'(ra); rd_sel_n = !rd; wr_sel_n = 1'b1; wdata = pend_w0;
        if (rd) begin
            d0 = lat_mode ? 3 : 2;
            exp_v[(h + d0) % 8] = 1'b1;
            exp_d[(h + d0) % 8] = model0[ra];
            exp_tag[(h + d0) % 8] = tag;
            exp_v[(h + d0 + 1) % 8] = 1'b1;
            exp_d[(h + d0 + 1) % 8] = model1[ra];
            exp_tag[(h + d0 + 1) % 8] = tag;
        end
        @(negedge clk2x); check_half();
        chk(k_phase === 1'b0, "R10", "k_phase before K#", int'(k_phase), 0);
        addr = AW'(wa); rd_sel_n = 1'b1; wr_sel_n = !wr; wdata = pend_w1;
        if (wr) begin
            model0[wa] = nw0;
            model1[wa] = nw1;
        end
        pend_w0 = nw0; pend_w1 = nw1;
        @(negedge clk2x); check_half();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) kcycle(0, 0, 0, 0, 8'h00, 8'h00, "R6");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; exp_tag[i] = "R6"; end
        pend_w0 = '0; pend_w1 = '0;
        rst_n = 1'b0; lat_mode = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
        addr = '0; wdata = '0;
        repeat (3) @(posedge clk2x);
        @(negedge clk2x);
        // R11: reset values
        chk(rvalid === 1'b0, "R11", "rvalid in reset", int'(rvalid), 0);
        chk(rdata === '0, "R11", "rdata in reset", int'(rdata), 0);
        chk(k_phase === 1'b1, "R11", "k_phase in reset", int'(k_phase), 1);
        prev_echo = echo_clk;
        rst_n = 1'b1;

        // R7 (short latency): write a in cycle a, read a-1 in cycle a
        for (int i = 0; i <= DEPTH; i++)
            kcycle(i > 0, i - 1, i < DEPTH, i % DEPTH,
                   8'(i * 17 + 3), 8'(i * 29 + 101), "R7");
        idle(3);

        // R3/R4: back-to-back reads of every address, short latency
        for (int i = 0; i < DEPTH; i++) kcycle(1, i, 0, 0, 8'h00, 8'h00, "R4");
        idle(1);
        for (int i = DEPTH - 1; i >= 0; i--) kcycle(1, i, 0, 0, 8'h00, 8'h00, "R3");
        idle(3);

        // R8 (long latency): read and write of the same address in one cycle
        lat_mode = 1'b1;
        for (int i = 0; i < DEPTH; i++)
            kcycle(1, i, 1, i, 8'(i * 7 + 66), 8'(255 - i * 13), "R8");
        idle(3);

        // R5: back-to-back reads, long latency
        for (int i = 0; i < DEPTH; i++) kcycle(1, i, 0, 0, 8'h00, 8'h00, "R5");
        idle(3);

        // R9: concurrent read and write every cycle, long latency, forwarding
        for (int i = 0; i <= DEPTH; i++)
            kcycle(i > 0, (i + DEPTH - 1) % DEPTH, i < DEPTH, i % DEPTH,
                   8'(i * 41 + 9), 8'(i * 3 + 200), "R9");
        idle(3);

        // R1: deselected reads with addresses moving produce no beats
        vtag = "R1";
        for (int i = 0; i < 6; i++) kcycle(0, i, 0, 0, 8'h00, 8'h00, "R1");
        vtag = "R6";

        // R2: deselected writes with live address and data leave memory alone
        lat_mode = 1'b0;
        idle(1);
        for (int i = 0; i < DEPTH; i++)
            kcycle(0, 0, 0, i, 8'hEE, 8'hDD, "R2");
        idle(2);
        for (int i = 0; i < DEPTH; i++) kcycle(1, i, 0, 0, 8'h00, 8'h00, "R2");
        idle(4);

        done = 1;
        summary();
        $finish;
    end

endmodule